// File: doc/BRIEF.md
# Unique-Read Timestamp Counter

This block is a free-running timestamp counter for reads that may come faster than the time base advances. The value it returns has two parts. The upper part is the real tick count, which moves forward by one on every cycle in which the tick enable is high. The lower part is a short sequence field that numbers the reads made since the most recent tick. Two reads inside one tick period therefore return different values, and later reads return larger values. Only the upper part carries time. The lower bits give an ordering inside one tick and are not a fraction of a tick.

A requester pulses the read strobe for one cycle. One cycle later the block presents the captured value on the read data output and raises the valid flag. The sequence field is kept by a small state machine with three states. SEQ_ZERO means no read has been made since the last tick. SEQ_RUN means the field is between one and one below its maximum. SEQ_FULL means the field is at its maximum and holds there.

The machine has four named transitions:
- T_TICK: a tick without a read; any state goes to SEQ_ZERO.
- T_TICK_READ: a tick and a read in the same cycle; any state goes to SEQ_RUN, or to SEQ_FULL when the field maximum is one.
- T_READ: a read without a tick; SEQ_ZERO or SEQ_RUN moves up by one, to SEQ_RUN or SEQ_FULL.
- T_HOLD: neither input, or a read while in SEQ_FULL; the state does not change.

Top module: `unique_read_tsc`

## Requirements
- R1: After reset, rd_valid is 0, rd_data is 0, and the internal tick count and sequence field are both 0.
- R2: A strobe in cycle n produces rd_valid = 1 in cycle n+1, with rd_data = {tick count, sequence field} as seen by that read. The tick count occupies bits [TICK_W+SEQ_W-1:SEQ_W] and the sequence field occupies bits [SEQ_W-1:0]. rd_valid is 0 after any cycle without a strobe.
- R3: Each read made without a tick increments the sequence field by one, so a later read returns the earlier value plus one.
- R4: A tick without a read adds one to the tick count and clears the sequence field to 0. The next read returns the new count with a field of 0.
- R5: When a tick and a read fall in the same cycle, the read returns {count+1, 0}, and the sequence field becomes 1 afterwards.
- R6: The sequence field saturates at its all-ones value. Further reads within the same tick return the same value, never a smaller one.
- R7: Reads never change the tick count; only the tick enable does.
- R8: The tick count wraps from all-ones to 0 on the next tick.
- R9: rd_data keeps its last captured value in every cycle that follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the tick count by one this cycle |
| rd_strobe | input | 1 | Request a read this cycle |
| rd_data | output | TICK_W+SEQ_W | Captured value: tick count above, sequence field below |
| rd_valid | output | 1 | rd_data holds a new read this cycle |

## Verification
The bench builds the block with TICK_W = 12 and SEQ_W = 2 instead of the defaults of 60 and 4. With a field of two bits, saturation at 3 is reached after four reads. With a 12-bit count, the wrap from 4095 to 0 can be reached with a few thousand ticks. The stimulus mixes isolated reads, back-to-back reads, ticks that coincide with reads, and idle gaps. Each read is compared against a scoreboard model built from the requirements.

// File: rtl/urtc_pkg.sv
package urtc_pkg;

    typedef enum logic [1:0] {
        SEQ_ZERO = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FULL = 2'd2
    } seq_state_e;

endpackage

// File: rtl/urtc_tick_counter.sv
module urtc_tick_counter #(
    parameter int TICK_W = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [TICK_W-1:0] count_now,
    output logic [TICK_W-1:0] count_inc
);

    localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);

    logic [TICK_W-1:0] count_q;

    always_comb begin
        count_inc = count_q + TICK_ONE;
        count_now = count_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_en) begin
            count_q <= count_inc;
        end
    end

endmodule

// File: rtl/urtc_seq_fsm.sv
module urtc_seq_fsm
    import urtc_pkg::*;
#(
    parameter int SEQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             rd_strobe,
    output logic [SEQ_W-1:0] rd_field
);

    localparam logic [SEQ_W-1:0] SEQ_MAX = '1;
    localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);
    localparam seq_state_e AFTER_ONE = (SEQ_ONE == SEQ_MAX) ? SEQ_FULL : SEQ_RUN;

    seq_state_e       state_q, state_d;
    logic [SEQ_W-1:0] seq_q, seq_d;
    logic [SEQ_W-1:0] seq_up;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_ZERO;
            seq_q   <= '0;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
        end
    end

    // transitions
    always_comb begin
        seq_up  = seq_q + SEQ_ONE;
        state_d = state_q;
        seq_d   = seq_q;
        if (tick_en && rd_strobe) begin
            // T_TICK_READ
            state_d = AFTER_ONE;
            seq_d   = SEQ_ONE;
        end else if (tick_en) begin
            // T_TICK
            state_d = SEQ_ZERO;
            seq_d   = '0;
        end else if (rd_strobe) begin
            unique case (state_q)
                SEQ_ZERO: begin
                    // T_READ
                    state_d = AFTER_ONE;
                    seq_d   = SEQ_ONE;
                end
                SEQ_RUN: begin
                    // T_READ
                    state_d = (seq_up == SEQ_MAX) ? SEQ_FULL : SEQ_RUN;
                    seq_d   = seq_up;
                end
                SEQ_FULL: begin
                    // T_HOLD: saturated
                    state_d = SEQ_FULL;
                    seq_d   = SEQ_MAX;
                end
                default: begin
                    state_d = SEQ_ZERO;
                    seq_d   = '0;
                end
            endcase
        end
    end

    // outputs: field value handed to a read in this cycle
    always_comb begin
        if (tick_en) begin
            rd_field = '0;
        end else begin
            unique case (state_q)
                SEQ_ZERO: rd_field = '0;
                SEQ_RUN:  rd_field = seq_q;
                SEQ_FULL: rd_field = SEQ_MAX;
                default:  rd_field = '0;
            endcase
        end
    end

endmodule

// File: rtl/urtc_read_port.sv
module urtc_read_port #(
    parameter int RD_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_strobe,
    input  logic [RD_W-1:0] rd_value,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_strobe;
            if (rd_strobe) begin
                rd_data <= rd_value;
            end
        end
    end

endmodule

// File: rtl/unique_read_tsc.sv
module unique_read_tsc #(
    parameter int TICK_W = 60,
    parameter int SEQ_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    rd_strobe,
    output logic [TICK_W+SEQ_W-1:0] rd_data,
    output logic                    rd_valid
);

    localparam int RD_W = TICK_W + SEQ_W;

    logic [TICK_W-1:0] count_now;
    logic [TICK_W-1:0] count_inc;
    logic [SEQ_W-1:0]  rd_field;
    logic [RD_W-1:0]   rd_value;

    urtc_tick_counter #(.TICK_W(TICK_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .count_now (count_now),
        .count_inc (count_inc)
    );

    urtc_seq_fsm #(.SEQ_W(SEQ_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .rd_strobe (rd_strobe),
        .rd_field  (rd_field)
    );

    always_comb begin
        rd_value = {(tick_en ? count_inc : count_now), rd_field};
    end

    urtc_read_port #(.RD_W(RD_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .rd_value  (rd_value),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/urtc_checker.sv
module urtc_checker #(
    parameter int TICK_W = 60,
    parameter int SEQ_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_en,
    input logic                    rd_strobe,
    input logic [TICK_W+SEQ_W-1:0] rd_data,
    input logic                    rd_valid
);

    localparam int RD_W = TICK_W + SEQ_W;
    localparam logic [SEQ_W-1:0] SEQ_MAX = '1;

    logic            tick_since;
    logic            ticked_r;
    logic            have_prev;
    logic [RD_W-1:0] prev_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_since <= 1'b0;
            ticked_r   <= 1'b0;
            have_prev  <= 1'b0;
            prev_data  <= '0;
        end else begin
            if (rd_strobe) begin
                ticked_r   <= tick_since | tick_en;
                tick_since <= 1'b0;
            end else begin
                tick_since <= tick_since | tick_en;
            end
            if (rd_valid) begin
                have_prev <= 1'b1;
                prev_data <= rd_data;
            end
        end
    end

    // R2
    a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);
    // R9
    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));
    // R3
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && have_prev && !ticked_r && prev_data[SEQ_W-1:0] != SEQ_MAX)
        |-> rd_data == prev_data + RD_W'(1));
    // R6
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && have_prev && !ticked_r && prev_data[SEQ_W-1:0] == SEQ_MAX)
        |-> rd_data == prev_data);
    // R4
    a_r4_zero_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ticked_r) |-> rd_data[SEQ_W-1:0] == '0);

endmodule

bind unique_read_tsc urtc_checker #(.TICK_W(TICK_W), .SEQ_W(SEQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/unique_read_tsc_bench.sv
module unique_read_tsc_bench;

    localparam int  TICK_W = 12;
    localparam int  SEQ_W  = 2;
    localparam int  RD_W   = TICK_W + SEQ_W;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG = 20000;
    localparam logic [SEQ_W-1:0] FMAX = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic            rd_strobe = 1'b0;
    logic [RD_W-1:0] rd_data;
    logic            rd_valid;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [RD_W-1:0] exp_q[$];
    string           tag_q[$];
    logic [RD_W-1:0] last_read = '0;

    logic [TICK_W-1:0] m_tick  = '0;
    logic [SEQ_W-1:0]  m_field = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unique_read_tsc #(.TICK_W(TICK_W), .SEQ_W(SEQ_W)) u_unique_read_tsc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [RD_W-1:0] act, input logic [RD_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected item pushed for every read
    task automatic drive(input bit tk, input bit rd, input string tag);
        @(negedge clk);
        tick_en   = tk;
        rd_strobe = rd;
        if (rd) begin
            exp_q.push_back(tk ? {m_tick + TICK_W'(1), {SEQ_W{1'b0}}} : {m_tick, m_field});
            tag_q.push_back(tag);
        end
        if (tk) begin
            m_tick  = m_tick + TICK_W'(1);
            m_field = rd ? SEQ_W'(1) : '0;
        end else if (rd && m_field != FMAX) begin
            m_field = m_field + SEQ_W'(1);
        end
    endtask

    // monitor: pops and compares at negedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected valid", rd_data, '0);
                end else begin
                    logic [RD_W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rd_data == e, t, rd_data, e);
                    last_read = rd_data;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog", '0, '0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_valid == 1'b0, "R1 valid", {{(RD_W-1){1'b0}}, rd_valid}, '0);
        check(rd_data == '0, "R1 data", rd_data, '0);

        drive(0, 1, "R1 first read after reset");
        drive(0, 1, "R3 second read");
        drive(0, 1, "R3 third read");
        drive(0, 0, "");
        drive(0, 0, "");
        @(negedge clk);
        // R9 hold after idle cycles
        check(rd_data == {TICK_W'(0), SEQ_W'(2)}, "R9 hold", rd_data, {TICK_W'(0), SEQ_W'(2)});

        drive(0, 1, "R2 read reaches max");
        drive(0, 1, "R6 saturated read");
        drive(0, 1, "R6 saturated read again");
        drive(1, 0, "");
        drive(0, 1, "R4 read after tick");
        drive(0, 1, "R3 read after tick");
        drive(1, 1, "R5 tick with read");
        drive(0, 1, "R5 field one after joint cycle");
        drive(0, 0, "");
        drive(0, 0, "");
        drive(0, 0, "");
        drive(0, 1, "R7 count unchanged by reads");
        drive(1, 0, "");
        drive(1, 0, "");
        drive(0, 1, "R4 two ticks then read");

        for (int i = 0; i < 30; i++) begin
            drive(i % 3 == 0, i % 2 == 0, "R2 mixed pattern");
        end

        while (m_tick != '1) drive(1, 0, "");
        drive(0, 1, "R8 at all-ones");
        drive(1, 1, "R8 wrap with read");
        drive(0, 1, "R8 after wrap");
        drive(0, 0, "");
        drive(0, 0, "");
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all reads returned", RD_W'(exp_q.size()), '0);
        check(rd_data == last_read, "R9 hold at end", rd_data, last_read);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule